// File: doc/BRIEF.md
# Clock Request Output Gating Controller

This block decides, for every clock output of a clock generator, whether that output runs or is held off, and how a stopped differential output presents itself on the board. It covers four groups: six request-controllable differential reference outputs, two differential programmable-frequency outputs, three differential CPU outputs and five single-ended outputs. The inputs are two active-low request pins, an active-low CPU stop pin and static configuration fields, which arrive here as plain inputs.

Each output has its own clock. The pins that can stop an output pass through a two-flop synchronizer in that output's domain. A small per-output state machine is updated only on the falling edge of its clock, so a gated clock starts and stops only on whole pulses.

Each output's gate machine has two states. `GATE_OFF` holds the output off. `GATE_RUN` passes the clock. The transition named *start* (`GATE_OFF` to `GATE_RUN`) is taken at a falling edge when the output's enable condition is true. The transition named *stop* (`GATE_RUN` to `GATE_OFF`) is taken at a falling edge when that condition is false. Asynchronous reset places every machine in `GATE_OFF`.

Reference output index k (0..5) of the ports maps to channel numbers 0, 3, 4, 5, 6, 7 in that order.

Top module: `clkreq_gate_ctrl`

## Requirements
- R1: While `rst_ni` is low, every gated output is off. For differential outputs this means true low, complement high and output enable high, given `diff_hiz_i` = 0. Every single-ended output is low.
- R2: A reference output whose bit in `ref_master_en_i` is 0 is off, whatever the request pins and masks are.
- R3: A reference output with its bit set in `ref_mask_a_i` is off while `req_a_ni` is 1 and runs while it is 0. It follows a pin change within four cycles of its own clock.
- R4: A reference output with its bit set in `ref_mask_b_i` is off while `req_b_ni` is 1 and runs while it is 0, with the same latency.
- R5: A reference output with both mask bits set is off if either request pin is 1, and runs only when both pins are 0.
- R6: A reference output with both mask bits clear runs whenever its master enable is 1. Neither request pin affects it.
- R7: Each programmable output runs exactly when its bit in `prog_en_i` is 1. The request pins and the stop pin have no effect on it.
- R8: A stopped differential output with `diff_hiz_i` = 0 drives true low, complement high and enable high. With `diff_hiz_i` = 1 it drives enable low and both true and complement low.
- R9: A CPU output whose `cpu_stop_en_i` bit is 1 is off while `cpu_stop_ni` is 0. When that bit is 0 the output runs whatever the pin does.
- R10: Each single-ended output runs exactly when its bit in `se_en_i` is 1.
- R11: An enable change made while an output's clock is high leaves that high phase whole. The gated output changes state only from the next low phase.
- R12: A running differential output drives its complement as the inverse of its true output, with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 6 | Source clock of each reference output |
| prog_clk_i | input | 2 | Source clock of each programmable output |
| cpu_clk_i | input | 3 | Source clock of each CPU output |
| se_clk_i | input | 5 | Source clock of each single-ended output |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_a_ni | input | 1 | Request pin A, 0 = run assigned outputs |
| req_b_ni | input | 1 | Request pin B, 0 = run assigned outputs |
| cpu_stop_ni | input | 1 | CPU stop pin, 0 = stop stoppable CPU outputs |
| ref_master_en_i | input | 6 | Master enable per reference output |
| ref_mask_a_i | input | 6 | 1 = reference output follows pin A |
| ref_mask_b_i | input | 6 | 1 = reference output follows pin B |
| prog_en_i | input | 2 | Enable per programmable output |
| cpu_stop_en_i | input | 3 | 1 = CPU output obeys the stop pin |
| se_en_i | input | 5 | Enable per single-ended output |
| diff_hiz_i | input | 1 | Stopped differential state: 0 driven, 1 high impedance |
| ref_p_o | output | 6 | Reference true outputs |
| ref_n_o | output | 6 | Reference complement outputs |
| ref_oe_o | output | 6 | Reference output enables |
| prog_p_o | output | 2 | Programmable true outputs |
| prog_n_o | output | 2 | Programmable complement outputs |
| prog_oe_o | output | 2 | Programmable output enables |
| cpu_p_o | output | 3 | CPU true outputs |
| cpu_n_o | output | 3 | CPU complement outputs |
| cpu_oe_o | output | 3 | CPU output enables |
| se_o | output | 5 | Single-ended gated clocks |

## Verification
The hardest case to reach from the ports is an enable change that lands inside a high phase of the output clock. If the gate were wrong, that is where a truncated pulse would appear. The bench reaches it by changing the enable one time unit after a rising edge and sampling the output later in the same high phase, then again in the following high phase. The case where both request masks are set is also hard, because it needs each pin raised in turn while the other stays low. The bench walks through all four pin combinations with both masks set.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [0:0] {
        GATE_OFF = 1'b0,
        GATE_RUN = 1'b1
    } gate_state_e;

    localparam int unsigned REF_OUTS  = 6;
    localparam int unsigned PROG_OUTS = 2;
    localparam int unsigned CPU_OUTS  = 3;
    localparam int unsigned SE_OUTS   = 5;

endpackage

// File: rtl/pin_sync2.sv
module pin_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic pin_o
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
        end
    end

    assign pin_o = stage2_q;
endmodule

// File: rtl/req_policy.sv
module req_policy (
    input  logic master_en_i,
    input  logic mask_a_i,
    input  logic mask_b_i,
    input  logic pin_a_hi_i,
    input  logic pin_b_hi_i,
    output logic want_o
);
    logic veto_a;
    logic veto_b;

    always_comb begin
        veto_a = mask_a_i & pin_a_hi_i;
        veto_b = mask_b_i & pin_b_hi_i;
        want_o = master_en_i & ~veto_a & ~veto_b;
    end
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import clkgate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic want_i,
    output logic on_o
);
    gate_state_e state_q;
    gate_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (want_i)  state_d = GATE_RUN;
            GATE_RUN: if (!want_i) state_d = GATE_OFF;
            default:               state_d = GATE_OFF;
        endcase
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= GATE_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        on_o = (state_q == GATE_RUN);
    end

    AST_RUN_ONLY_WHEN_WANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GATE_RUN) && $stable(want_i) && !want_i |=> (state_q == GATE_OFF)) // R11
        else $error("gate left running after enable dropped");
endmodule

// File: rtl/diff_out.sv
module diff_out (
    input  logic clk_i,
    input  logic on_i,
    input  logic hiz_i,
    output logic p_o,
    output logic n_o,
    output logic oe_o
);
    always_comb begin
        if (on_i) begin
            p_o  = clk_i;
            n_o  = ~clk_i;
            oe_o = 1'b1;
        end else if (hiz_i) begin
            p_o  = 1'b0;
            n_o  = 1'b0;
            oe_o = 1'b0;
        end else begin
            p_o  = 1'b0;
            n_o  = 1'b1;
            oe_o = 1'b1;
        end
    end

    always_comb begin
        if (oe_o) begin
            AST_PAIR_NOT_BOTH_HIGH: assert (!(p_o && n_o)) // R12
                else $error("true and complement both high");
        end
    end
endmodule

// File: rtl/clkreq_gate_ctrl.sv
module clkreq_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int unsigned N_REF  = REF_OUTS,
    parameter int unsigned N_PROG = PROG_OUTS,
    parameter int unsigned N_CPU  = CPU_OUTS,
    parameter int unsigned N_SE   = SE_OUTS
) (
    input  logic [N_REF-1:0]  ref_clk_i,
    input  logic [N_PROG-1:0] prog_clk_i,
    input  logic [N_CPU-1:0]  cpu_clk_i,
    input  logic [N_SE-1:0]   se_clk_i,
    input  logic              rst_ni,
    input  logic              req_a_ni,
    input  logic              req_b_ni,
    input  logic              cpu_stop_ni,
    input  logic [N_REF-1:0]  ref_master_en_i,
    input  logic [N_REF-1:0]  ref_mask_a_i,
    input  logic [N_REF-1:0]  ref_mask_b_i,
    input  logic [N_PROG-1:0] prog_en_i,
    input  logic [N_CPU-1:0]  cpu_stop_en_i,
    input  logic [N_SE-1:0]   se_en_i,
    input  logic              diff_hiz_i,
    output logic [N_REF-1:0]  ref_p_o,
    output logic [N_REF-1:0]  ref_n_o,
    output logic [N_REF-1:0]  ref_oe_o,
    output logic [N_PROG-1:0] prog_p_o,
    output logic [N_PROG-1:0] prog_n_o,
    output logic [N_PROG-1:0] prog_oe_o,
    output logic [N_CPU-1:0]  cpu_p_o,
    output logic [N_CPU-1:0]  cpu_n_o,
    output logic [N_CPU-1:0]  cpu_oe_o,
    output logic [N_SE-1:0]   se_o
);

    // Reference outputs: request pins synchronized per output clock
    for (genvar i = 0; i < N_REF; i++) begin : g_ref
        logic pin_a_lvl;
        logic pin_b_lvl;
        logic want;
        logic on;
        logic armed_q;

        pin_sync2 #(.RST_VAL(1'b0)) u_sync_a (
            .clk_i(ref_clk_i[i]), .rst_ni(rst_ni), .pin_i(req_a_ni), .pin_o(pin_a_lvl));
        pin_sync2 #(.RST_VAL(1'b0)) u_sync_b (
            .clk_i(ref_clk_i[i]), .rst_ni(rst_ni), .pin_i(req_b_ni), .pin_o(pin_b_lvl));

        req_policy u_policy (
            .master_en_i(ref_master_en_i[i]),
            .mask_a_i   (ref_mask_a_i[i]),
            .mask_b_i   (ref_mask_b_i[i]),
            .pin_a_hi_i (pin_a_lvl),
            .pin_b_hi_i (pin_b_lvl),
            .want_o     (want));

        gate_fsm u_gate (
            .clk_i(ref_clk_i[i]), .rst_ni(rst_ni), .want_i(want), .on_o(on));

        diff_out u_drv (
            .clk_i(ref_clk_i[i]), .on_i(on), .hiz_i(diff_hiz_i),
            .p_o(ref_p_o[i]), .n_o(ref_n_o[i]), .oe_o(ref_oe_o[i]));

        always_ff @(negedge ref_clk_i[i] or negedge rst_ni) begin
            if (!rst_ni) armed_q <= 1'b0;
            else         armed_q <= 1'b1;
        end

        AST_REF_MASTER_OFF: assert property (@(negedge ref_clk_i[i]) disable iff (!rst_ni)
            armed_q && $past(!ref_master_en_i[i]) |-> !ref_p_o[i]) // R2
            else $error("reference output ran with master enable clear");
        AST_DIFF_DRIVEN_STOP: assert property (@(negedge ref_clk_i[i]) disable iff (!rst_ni)
            armed_q && $past(!ref_master_en_i[i]) && !diff_hiz_i |-> ref_oe_o[i] && ref_n_o[i]) // R8
            else $error("driven stop state wrong");
        AST_DIFF_HIZ_STOP: assert property (@(negedge ref_clk_i[i]) disable iff (!rst_ni)
            armed_q && $past(!ref_master_en_i[i]) && diff_hiz_i |-> !ref_oe_o[i]) // R8
            else $error("high impedance stop state wrong");
    end

    // Programmable outputs: own enable only
    for (genvar j = 0; j < N_PROG; j++) begin : g_prog
        logic on;
        logic armed_q;

        gate_fsm u_gate (
            .clk_i(prog_clk_i[j]), .rst_ni(rst_ni), .want_i(prog_en_i[j]), .on_o(on));

        diff_out u_drv (
            .clk_i(prog_clk_i[j]), .on_i(on), .hiz_i(diff_hiz_i),
            .p_o(prog_p_o[j]), .n_o(prog_n_o[j]), .oe_o(prog_oe_o[j]));

        always_ff @(negedge prog_clk_i[j] or negedge rst_ni) begin
            if (!rst_ni) armed_q <= 1'b0;
            else         armed_q <= 1'b1;
        end

        AST_PROG_RUNS: assert property (@(negedge prog_clk_i[j]) disable iff (!rst_ni)
            armed_q && $past(prog_en_i[j]) |-> prog_p_o[j]) // R7
            else $error("programmable output not running");
        AST_PROG_HALTS: assert property (@(negedge prog_clk_i[j]) disable iff (!rst_ni)
            armed_q && $past(!prog_en_i[j]) |-> !prog_p_o[j]) // R7
            else $error("programmable output running while disabled");
    end

    // CPU outputs: stop pin synchronized per output clock
    for (genvar k = 0; k < N_CPU; k++) begin : g_cpu
        logic stop_lvl;
        logic want;
        logic on;
        logic armed_q;

        pin_sync2 #(.RST_VAL(1'b1)) u_sync_stop (
            .clk_i(cpu_clk_i[k]), .rst_ni(rst_ni), .pin_i(cpu_stop_ni), .pin_o(stop_lvl));

        always_comb want = ~(cpu_stop_en_i[k] & ~stop_lvl);

        gate_fsm u_gate (
            .clk_i(cpu_clk_i[k]), .rst_ni(rst_ni), .want_i(want), .on_o(on));

        diff_out u_drv (
            .clk_i(cpu_clk_i[k]), .on_i(on), .hiz_i(diff_hiz_i),
            .p_o(cpu_p_o[k]), .n_o(cpu_n_o[k]), .oe_o(cpu_oe_o[k]));

        always_ff @(negedge cpu_clk_i[k] or negedge rst_ni) begin
            if (!rst_ni) armed_q <= 1'b0;
            else         armed_q <= 1'b1;
        end

        AST_CPU_FREE_RUN: assert property (@(negedge cpu_clk_i[k]) disable iff (!rst_ni)
            armed_q && $past(!cpu_stop_en_i[k]) |-> cpu_p_o[k]) // R9
            else $error("free-running CPU output halted");
    end

    // Single-ended outputs: plain enable
    for (genvar m = 0; m < N_SE; m++) begin : g_se
        logic on;
        logic armed_q;

        gate_fsm u_gate (
            .clk_i(se_clk_i[m]), .rst_ni(rst_ni), .want_i(se_en_i[m]), .on_o(on));

        always_comb se_o[m] = se_clk_i[m] & on;

        always_ff @(negedge se_clk_i[m] or negedge rst_ni) begin
            if (!rst_ni) armed_q <= 1'b0;
            else         armed_q <= 1'b1;
        end

        AST_SE_FOLLOWS: assert property (@(negedge se_clk_i[m]) disable iff (!rst_ni)
            armed_q && $past(se_en_i[m]) |-> se_o[m]) // R10
            else $error("single-ended output not running");
    end

endmodule

// File: tb/clkreq_gate_ctrl_tb.sv
module clkreq_gate_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst_ni;
    logic       req_a_ni, req_b_ni, cpu_stop_ni;
    logic [5:0] master_en, mask_a, mask_b;
    logic [1:0] prog_en;
    logic [2:0] stop_en;
    logic [4:0] se_en;
    logic       hiz;

    logic [5:0] ref_p, ref_n, ref_oe;
    logic [1:0] prog_p, prog_n, prog_oe;
    logic [2:0] cpu_p, cpu_n, cpu_oe;
    logic [4:0] se_o;

    int n_checks = 0;
    int n_fail = 0;

    clkreq_gate_ctrl u_dut (
        .ref_clk_i({6{clk}}), .prog_clk_i({2{clk}}), .cpu_clk_i({3{clk}}), .se_clk_i({5{clk}}),
        .rst_ni(rst_ni), .req_a_ni(req_a_ni), .req_b_ni(req_b_ni), .cpu_stop_ni(cpu_stop_ni),
        .ref_master_en_i(master_en), .ref_mask_a_i(mask_a), .ref_mask_b_i(mask_b),
        .prog_en_i(prog_en), .cpu_stop_en_i(stop_en), .se_en_i(se_en), .diff_hiz_i(hiz),
        .ref_p_o(ref_p), .ref_n_o(ref_n), .ref_oe_o(ref_oe),
        .prog_p_o(prog_p), .prog_n_o(prog_n), .prog_oe_o(prog_oe),
        .cpu_p_o(cpu_p), .cpu_n_o(cpu_n), .cpu_oe_o(cpu_oe), .se_o(se_o));

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Wait for sync plus gate latency, then sample in a high phase
    task automatic settle();
        repeat (5) @(posedge clk);
        #2;
    endtask

    // Model of all outputs during a high phase, from the requirements
    task automatic check_all(input string req);
        logic [5:0] r_on;
        logic [2:0] c_on;
        r_on = master_en & ~(mask_a & {6{req_a_ni}}) & ~(mask_b & {6{req_b_ni}});
        c_on = ~(stop_en & {3{~cpu_stop_ni}});
        chk(req, "ref_p",   {2'b0, ref_p},   {2'b0, r_on});
        chk(req, "ref_n",   {2'b0, ref_n},   {2'b0, hiz ? 6'b0 : ~r_on});
        chk(req, "ref_oe",  {2'b0, ref_oe},  {2'b0, r_on | {6{~hiz}}});
        chk(req, "prog_p",  {6'b0, prog_p},  {6'b0, prog_en});
        chk(req, "prog_oe", {6'b0, prog_oe}, {6'b0, prog_en | {2{~hiz}}});
        chk(req, "cpu_p",   {5'b0, cpu_p},   {5'b0, c_on});
        chk(req, "cpu_n",   {5'b0, cpu_n},   {5'b0, hiz ? 3'b0 : ~c_on});
        chk(req, "se",      {3'b0, se_o},    {3'b0, se_en});
    endtask

    task automatic t_reset();
        #2;
        chk("R1", "ref_p",  {2'b0, ref_p},  8'h00);
        chk("R1", "ref_n",  {2'b0, ref_n},  8'h3f);
        chk("R1", "ref_oe", {2'b0, ref_oe}, 8'h3f);
        chk("R1", "cpu_p",  {5'b0, cpu_p},  8'h00);
        chk("R1", "se",     {3'b0, se_o},   8'h00);
    endtask

    task automatic t_defaults();   // R6 unassigned outputs run
        settle();
        check_all("R6");
    endtask

    task automatic t_master();     // R2
        master_en = 6'b101010;
        mask_a = 6'b000011; req_a_ni = 1'b0;
        settle(); check_all("R2");
        master_en = 6'b111111; mask_a = 6'b0;
        settle(); check_all("R2");
    endtask

    task automatic t_req_a();      // R3
        mask_a = 6'b001101;
        req_a_ni = 1'b1; settle(); check_all("R3");
        chk("R3", "ref_p masked off", {2'b0, ref_p}, 8'h32);
        req_a_ni = 1'b0; settle(); check_all("R3");
        mask_a = 6'b0;
    endtask

    task automatic t_req_b();      // R4
        mask_b = 6'b110000;
        req_b_ni = 1'b1; settle(); check_all("R4");
        chk("R4", "ref_p masked off", {2'b0, ref_p}, 8'h0f);
        req_b_ni = 1'b0; settle(); check_all("R4");
        mask_b = 6'b0;
    endtask

    task automatic t_both();       // R5, R6
        mask_a = 6'b000001; mask_b = 6'b000001;
        for (int c = 0; c < 4; c++) begin
            req_a_ni = c[0]; req_b_ni = c[1];
            settle();
            check_all("R5");
            chk("R5", "both-mask output", {7'b0, ref_p[0]}, {7'b0, (c == 0)});
            chk("R6", "unmasked outputs", {2'b0, ref_p & 6'b111110}, 8'h3e);
        end
        req_a_ni = 1'b0; req_b_ni = 1'b0; mask_a = 6'b0; mask_b = 6'b0;
    endtask

    task automatic t_prog();       // R7
        prog_en = 2'b01;
        req_a_ni = 1'b1; req_b_ni = 1'b1; cpu_stop_ni = 1'b0; stop_en = 3'b000;
        settle(); check_all("R7");
        prog_en = 2'b10; settle(); check_all("R7");
        req_a_ni = 1'b0; req_b_ni = 1'b0; cpu_stop_ni = 1'b1; prog_en = 2'b11; stop_en = 3'b111;
        settle(); check_all("R7");
    endtask

    task automatic t_mode();       // R8, R12
        master_en = 6'b000111; prog_en = 2'b10;
        hiz = 1'b0; settle(); check_all("R8");
        hiz = 1'b1; settle(); check_all("R8");
        chk("R8", "hiz ref_oe", {2'b0, ref_oe}, 8'h07);
        chk("R12", "running comp low in high phase", {2'b0, ref_n}, 8'h00);
        @(negedge clk); #2;
        chk("R12", "running comp high in low phase", {2'b0, ref_n & 6'b000111}, 8'h07);
        hiz = 1'b0; master_en = 6'b111111; prog_en = 2'b11;
    endtask

    task automatic t_cpu_stop();   // R9
        stop_en = 3'b101; cpu_stop_ni = 1'b0;
        settle(); check_all("R9");
        chk("R9", "cpu_p", {5'b0, cpu_p}, 8'h02);
        stop_en = 3'b000; settle(); check_all("R9");
        stop_en = 3'b111; cpu_stop_ni = 1'b1; settle(); check_all("R9");
    endtask

    task automatic t_se();         // R10
        se_en = 5'b10110; settle(); check_all("R10");
        se_en = 5'b11111; settle(); check_all("R10");
    endtask

    task automatic t_no_runt();    // R11
        @(posedge clk); #1;
        prog_en = 2'b00;
        #3 chk("R11", "high phase kept on disable", {6'b0, prog_p}, 8'h03);
        @(posedge clk); #2;
        chk("R11", "off after low phase", {6'b0, prog_p}, 8'h00);
        #1 prog_en = 2'b11;
        #1 chk("R11", "no pulse mid high phase", {6'b0, prog_p}, 8'h00);
        @(posedge clk); #2;
        chk("R11", "on after low phase", {6'b0, prog_p}, 8'h03);
    endtask

    initial begin
        rst_ni = 1'b0;
        req_a_ni = 1'b0; req_b_ni = 1'b0; cpu_stop_ni = 1'b1;
        master_en = 6'h3f; mask_a = 6'h0; mask_b = 6'h0;
        prog_en = 2'b11; stop_en = 3'b111; se_en = 5'h1f; hiz = 1'b0;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); #2 rst_ni = 1'b1;
        t_defaults();
        t_master();
        t_req_a();
        t_req_b();
        t_both();
        t_prog();
        t_mode();
        t_cpu_stop();
        t_se();
        t_no_runt();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule